// File: doc/BRIEF.md
# Two-Descriptor DMA Sequencer

This block drives a transfer engine through a reduced DMA mode. Software loads two descriptors into fixed register slots: slot A moves data from memory into the local buffer, and slot B moves data from the buffer back to memory. It then writes a start command to the control register. The sequencer hands slot A to the engine first. It hands slot B over only after slot A has finished cleanly. Each slot records its own outcome in its status word. The overall result appears on the channel-zero bits of the status register and on three output pins.

Each slot has a next-pointer word. This word always reads as zero and cannot be written, because no chaining is possible. A slot can be marked conditional, but this mode does not support conditional descriptors. Such a slot is rejected without being issued, and the sequence stops.

The state machine has five states:
- `ST_IDLE` waits for an accepted start and goes to `ST_LAUNCH_M2B`.
- `ST_LAUNCH_M2B` returns to `ST_IDLE` if slot A is conditional. Otherwise it pulses the engine start and goes to `ST_WAIT_M2B`.
- `ST_WAIT_M2B` waits for the engine's done signal. On an error it returns to `ST_IDLE`. On success it goes to `ST_LAUNCH_B2M`.
- `ST_LAUNCH_B2M` rejects a conditional slot B and returns to `ST_IDLE`. Otherwise it pulses start and goes to `ST_WAIT_B2M`.
- `ST_WAIT_B2M` returns to `ST_IDLE` on done.

Top module: `dual_desc_dma_seq`

## Requirements
- R1: Slot A occupies register offsets 0x20..0x2C and slot B occupies 0x30..0x3C. Within a slot the words are laid out as follows:
  - +0x0 is the control word: bit 0 is the conditional flag and bits 31:16 are the length.
  - +0x4 is the next pointer.
  - +0x8 is the address.
  - +0xC is the status word: bit 0 done, bit 1 error, bit 2 rejected.
  - The control and address words read back exactly as written.
- R2: The next-pointer word of both slots reads zero, and writes to it have no effect.
- R3: A write to offset 0x00 with bit 0 set starts a sequence only if the same word has bit 1 (mode) and bit 2 (channel-zero enable) set. Otherwise no transfer is issued and all status stays unchanged.
- R4: Slot A is always issued first with eng_dir=0 and its address and length. Slot B is issued with eng_dir=1 only after slot A completes without error.
- R5: Each issue is a single-cycle eng_start pulse.
- R6: When both slots succeed, both slot status words read 0b001. Status register 0x04 reads busy=0 (bit 0), done=1 (bit 1) and error=0 (bit 2). seq_done=1.
- R7: An error reported on slot A sets slot A status to 0b010, leaves slot B status at 0, issues nothing more and sets the channel error bit.
- R8: An error reported on slot B leaves slot A at 0b001, sets slot B to 0b010 and sets the channel error bit.
- R9: A slot whose conditional flag is set is never issued. Its status becomes 0b110, the sequence stops and the channel error bit is set.
- R10: Writes to slot control and address words while busy have no effect.
- R11: A start command while busy is ignored.
- R12: After reset, and at each accepted start, all slot and channel status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Register access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 8 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| eng_start | output | 1 | One-cycle transfer request |
| eng_dir | output | 1 | 0 memory-to-buffer, 1 buffer-to-memory |
| eng_addr | output | 32 | Memory address of the issued slot |
| eng_len | output | 16 | Length of the issued slot |
| eng_done | input | 1 | Engine finished the current transfer |
| eng_err | input | 1 | Error qualifier of eng_done |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Both slots completed cleanly |
| seq_err | output | 1 | Sequence ended with an error or rejection |

## Verification
The bench sweeps every combination of conditional flags on A and B, an engine error on A and on B, and two engine latencies. This separates four outcomes: a clean pass, a stop after A, a failure in B, and a rejection before any issue. Each slot receives different addresses and lengths, so a swapped slot or a wrong direction shows up in the engine log. All three start commands that lack the mode bit or the enable bit are applied to show they change nothing. A dedicated run writes descriptors and a second start while busy to show the sequence and the stored slot values are unaffected.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH_M2B,
        ST_WAIT_M2B,
        ST_LAUNCH_B2M,
        ST_WAIT_B2M
    } seq_state_e;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_SLOT_A = 8'h20;
    localparam logic [7:0] OFS_SLOT_B = 8'h30;

    localparam int WORD_CTRL = 0;
    localparam int WORD_NEXT = 1;
    localparam int WORD_ADDR = 2;
    localparam int WORD_STAT = 3;

    localparam int BIT_GO   = 0;
    localparam int BIT_MODE = 1;
    localparam int BIT_EN   = 2;

    localparam logic [2:0] SLOT_OK  = 3'b001;
    localparam logic [2:0] SLOT_ERR = 3'b010;
    localparam logic [2:0] SLOT_REJ = 3'b110;

    function automatic logic [7:0] slot_base(input int idx);
        return (idx == 0) ? OFS_SLOT_A : OFS_SLOT_B;
    endfunction

endpackage

// File: rtl/dds_regs.sv
module dds_regs
    import dds_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int PADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PADDR_W-1:0]          waddr,
    input  logic [31:0]                 wdata,
    input  logic                        busy,
    output logic                        mode_q,
    output logic                        en_q,
    output logic                        start_req,
    output logic [1:0]                  d_cond,
    output logic [1:0][LEN_W-1:0]       d_len,
    output logic [1:0][ADDR_W-1:0]      d_addr
);
    localparam logic [PADDR_W-1:0] A_CTRL = PADDR_W'(OFS_CTRL);

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (waddr == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (ctrl_hit) begin
            mode_q <= wdata[BIT_MODE];
            en_q   <= wdata[BIT_EN];
        end
    end

    assign start_req = ctrl_hit && !busy && wdata[BIT_GO]
                       && wdata[BIT_MODE] && wdata[BIT_EN];

    for (genvar i = 0; i < 2; i++) begin : g_slot
        localparam logic [PADDR_W-1:0] A_DCTRL =
            PADDR_W'(slot_base(i) + 8'(WORD_CTRL * 4));
        localparam logic [PADDR_W-1:0] A_DADDR =
            PADDR_W'(slot_base(i) + 8'(WORD_ADDR * 4));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_cond[i] <= 1'b0;
                d_len[i]  <= '0;
                d_addr[i] <= '0;
            end else if (wr_en && !busy) begin
                if (waddr == A_DCTRL) begin
                    d_cond[i] <= wdata[0];
                    d_len[i]  <= wdata[16 +: LEN_W];
                end
                if (waddr == A_DADDR) begin
                    d_addr[i] <= wdata[ADDR_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/dds_fsm.sv
module dds_fsm
    import dds_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_req,
    input  logic [1:0]                  d_cond,
    input  logic [1:0][LEN_W-1:0]       d_len,
    input  logic [1:0][ADDR_W-1:0]      d_addr,
    input  logic                        eng_done,
    input  logic                        eng_err,
    output logic                        eng_start,
    output logic                        eng_dir,
    output logic [ADDR_W-1:0]           eng_addr,
    output logic [LEN_W-1:0]            eng_len,
    output logic                        busy,
    output logic                        ch_done,
    output logic                        ch_err,
    output logic [2:0]                  stat_m2b,
    output logic [2:0]                  stat_b2m
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_req) state_d = ST_LAUNCH_M2B;
            ST_LAUNCH_M2B: state_d = d_cond[0] ? ST_IDLE : ST_WAIT_M2B;
            ST_WAIT_M2B:   if (eng_done) state_d = eng_err ? ST_IDLE : ST_LAUNCH_B2M;
            ST_LAUNCH_B2M: state_d = d_cond[1] ? ST_IDLE : ST_WAIT_B2M;
            ST_WAIT_B2M:   if (eng_done) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        eng_start = 1'b0;
        eng_dir   = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_LAUNCH_M2B: eng_start = !d_cond[0];
            ST_WAIT_M2B:   eng_dir = 1'b0;
            ST_LAUNCH_B2M: begin
                eng_dir   = 1'b1;
                eng_start = !d_cond[1];
            end
            ST_WAIT_B2M:   eng_dir = 1'b1;
            default:       busy = 1'b0;
        endcase
        eng_addr = d_addr[eng_dir];
        eng_len  = d_len[eng_dir];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_m2b <= '0;
            stat_b2m <= '0;
            ch_done  <= 1'b0;
            ch_err   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_req) begin
                    stat_m2b <= '0;
                    stat_b2m <= '0;
                    ch_done  <= 1'b0;
                    ch_err   <= 1'b0;
                end
                ST_LAUNCH_M2B: if (d_cond[0]) begin
                    stat_m2b <= SLOT_REJ;
                    ch_err   <= 1'b1;
                end
                ST_WAIT_M2B: if (eng_done) begin
                    stat_m2b <= eng_err ? SLOT_ERR : SLOT_OK;
                    ch_err   <= eng_err;
                end
                ST_LAUNCH_B2M: if (d_cond[1]) begin
                    stat_b2m <= SLOT_REJ;
                    ch_err   <= 1'b1;
                end
                ST_WAIT_B2M: if (eng_done) begin
                    stat_b2m <= eng_err ? SLOT_ERR : SLOT_OK;
                    ch_err   <= eng_err;
                    ch_done  <= !eng_err;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dual_desc_dma_seq.sv
module dual_desc_dma_seq
    import dds_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int PADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [PADDR_W-1:0]    paddr,
    input  logic [31:0]           pwdata,
    output logic [31:0]           prdata,
    output logic                  eng_start,
    output logic                  eng_dir,
    output logic [ADDR_W-1:0]     eng_addr,
    output logic [LEN_W-1:0]      eng_len,
    input  logic                  eng_done,
    input  logic                  eng_err,
    output logic                  busy,
    output logic                  seq_done,
    output logic                  seq_err
);
    logic                   wr_en;
    logic                   mode_q, en_q, start_req;
    logic [1:0]             d_cond;
    logic [1:0][LEN_W-1:0]  d_len;
    logic [1:0][ADDR_W-1:0] d_addr;
    logic [2:0]             stat_m2b, stat_b2m;
    logic                   ch_done, ch_err;

    assign wr_en = psel && penable && pwrite;

    dds_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PADDR_W(PADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(paddr),
        .wdata(pwdata), .busy(busy), .mode_q(mode_q), .en_q(en_q),
        .start_req(start_req), .d_cond(d_cond), .d_len(d_len),
        .d_addr(d_addr)
    );

    dds_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .d_cond(d_cond), .d_len(d_len), .d_addr(d_addr),
        .eng_done(eng_done), .eng_err(eng_err), .eng_start(eng_start),
        .eng_dir(eng_dir), .eng_addr(eng_addr), .eng_len(eng_len),
        .busy(busy), .ch_done(ch_done), .ch_err(ch_err),
        .stat_m2b(stat_m2b), .stat_b2m(stat_b2m)
    );

    assign seq_done = ch_done;
    assign seq_err  = ch_err;

    always_comb begin
        prdata = '0;
        if (paddr == PADDR_W'(OFS_CTRL)) begin
            prdata[BIT_MODE] = mode_q;
            prdata[BIT_EN]   = en_q;
        end else if (paddr == PADDR_W'(OFS_STAT)) begin
            prdata[2:0] = {ch_err, ch_done, busy};
        end
        for (int i = 0; i < 2; i++) begin
            if (paddr == PADDR_W'(slot_base(i) + 8'(WORD_CTRL * 4))) begin
                prdata[0]          = d_cond[i];
                prdata[16 +: LEN_W] = d_len[i];
            end
            if (paddr == PADDR_W'(slot_base(i) + 8'(WORD_ADDR * 4))) begin
                prdata[ADDR_W-1:0] = d_addr[i];
            end
            if (paddr == PADDR_W'(slot_base(i) + 8'(WORD_STAT * 4))) begin
                prdata[2:0] = (i == 0) ? stat_m2b : stat_b2m;
            end
        end
    end

endmodule

// File: rtl/dds_chk.sv
module dds_chk #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int PADDR_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [PADDR_W-1:0]          paddr,
    input logic [31:0]                 pwdata,
    input logic                        eng_start,
    input logic                        eng_dir,
    input logic                        eng_done,
    input logic                        eng_err,
    input logic                        busy,
    input logic                        seq_done,
    input logic                        seq_err,
    input logic [1:0]                  d_cond,
    input logic [1:0][LEN_W-1:0]       d_len,
    input logic [1:0][ADDR_W-1:0]      d_addr,
    input logic [2:0]                  stat_m2b,
    input logic [2:0]                  stat_b2m
);
    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R4
    b_after_clean_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_dir) |-> (stat_m2b == 3'b001));

    // R4
    a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !eng_dir) |-> (stat_m2b == 3'b000 && stat_b2m == 3'b000));

    // R7
    stop_on_a_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_start && eng_done && eng_err && !eng_dir)
        |=> (!busy && stat_b2m == 3'b000 && seq_err));

    // R9
    no_cond_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !d_cond[eng_dir]);

    // R10
    slots_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(d_addr) && $stable(d_len) && $stable(d_cond)));

    // R3
    gated_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && paddr == '0 && pwdata[0] && !(pwdata[1] && pwdata[2]))
        |=> !busy);

    // R6
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_err));
endmodule

bind dual_desc_dma_seq dds_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PADDR_W(PADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .paddr(paddr), .pwdata(pwdata),
    .eng_start(eng_start), .eng_dir(eng_dir), .eng_done(eng_done),
    .eng_err(eng_err), .busy(busy), .seq_done(seq_done), .seq_err(seq_err),
    .d_cond(d_cond), .d_len(d_len), .d_addr(d_addr),
    .stat_m2b(stat_m2b), .stat_b2m(stat_b2m)
);

// File: tb/sim_dual_desc_dma_seq.sv
`timescale 1ns/1ps
module sim_dual_desc_dma_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        eng_start, eng_dir, busy, seq_done, seq_err;
    logic [31:0] eng_addr;
    logic [15:0] eng_len;
    logic        eng_done = 1'b0, eng_err = 1'b0;

    int total = 0, bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    dual_desc_dma_seq u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .eng_start(eng_start), .eng_dir(eng_dir), .eng_addr(eng_addr),
        .eng_len(eng_len), .eng_done(eng_done), .eng_err(eng_err),
        .busy(busy), .seq_done(seq_done), .seq_err(seq_err)
    );

    // engine model
    int  lat = 1;
    bit  fail_a = 0, fail_b = 0;
    int  n_iss = 0;
    int  cnt = 0;
    bit  cur_dir = 0;
    logic        log_dir  [0:3];
    logic [31:0] log_addr [0:3];
    logic [15:0] log_len  [0:3];

    always @(negedge clk) begin
        eng_done = 1'b0;
        eng_err  = 1'b0;
        if (eng_start) begin
            if (n_iss < 4) begin
                log_dir[n_iss]  = eng_dir;
                log_addr[n_iss] = eng_addr;
                log_len[n_iss]  = eng_len;
            end
            n_iss++;
            cur_dir = eng_dir;
            cnt = lat;
        end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                eng_done = 1'b1;
                eng_err  = cur_dir ? fail_b : fail_a;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 100) begin
            @(negedge clk);
            k++;
        end
        if (busy) check("R6 idle timeout", 32'(busy), 32'h0);
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(8'h04, v); check("R12 ch status reset", v, 0);
        rd(8'h2C, v); check("R12 slot A status reset", v, 0);
        rd(8'h3C, v); check("R12 slot B status reset", v, 0);
        check("R12 busy reset", 32'(busy), 0);

        // R1 / R2 readback
        wr(8'h20, 32'h1234_0001); rd(8'h20, v); check("R1 slot A ctrl", v, 32'h1234_0001);
        wr(8'h38, 32'hCAFE_0010); rd(8'h38, v); check("R1 slot B addr", v, 32'hCAFE_0010);
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); check("R2 slot A next", v, 0);
        wr(8'h34, 32'h0000_1000); rd(8'h34, v); check("R2 slot B next", v, 0);

        // R3 gated starts: mode/enable combinations without both bits
        wr(8'h20, 32'h0010_0000); wr(8'h30, 32'h0020_0000);
        for (int m = 0; m < 3; m++) begin
            n_iss = 0;
            wr(8'h00, 32'(1 | (m << 1)));
            repeat (3) @(negedge clk);
            check("R3 no issue", 32'(n_iss), 0);
            check("R3 busy low", 32'(busy), 0);
            rd(8'h04, v); check("R3 status unchanged", v, 0);
        end

        // R4..R9, R12 sweep
        for (int c = 0; c < 32; c++) begin
            bit ca, cb, ea, eb;
            logic [31:0] aa, ab;
            logic [15:0] la, lb;
            logic [2:0] sa, sb;
            bit iss_a, iss_b, ok;
            ca = c[0]; cb = c[1]; ea = c[2]; eb = c[3];
            lat = c[4] ? 3 : 1;
            fail_a = ea; fail_b = eb;
            aa = 32'h1000_0000 + 32'(c * 16'h0100);
            ab = 32'h2000_0000 + 32'(c * 16'h0040);
            la = 16'(c * 3 + 5);
            lb = 16'(c * 7 + 9);
            wr(8'h20, {la, 15'b0, ca});
            wr(8'h28, aa);
            wr(8'h30, {lb, 15'b0, cb});
            wr(8'h38, ab);
            n_iss = 0;
            wr(8'h00, 32'h7);
            wait_idle();
            repeat (lat + 2) @(negedge clk);

            iss_a = !ca;
            iss_b = !ca && !ea && !cb;
            sa = ca ? 3'b110 : (ea ? 3'b010 : 3'b001);
            sb = (ca || ea) ? 3'b000 : (cb ? 3'b110 : (eb ? 3'b010 : 3'b001));
            ok = (sa == 3'b001) && (sb == 3'b001);

            check("R4/R9 issue count", 32'(n_iss), 32'(int'(iss_a) + int'(iss_b)));
            if (iss_a && n_iss > 0) begin
                check("R4 A dir", 32'(log_dir[0]), 0);
                check("R4 A addr", log_addr[0], aa);
                check("R4 A len", 32'(log_len[0]), 32'(la));
            end
            if (iss_b && n_iss > 1) begin
                check("R4 B dir", 32'(log_dir[1]), 1);
                check("R4 B addr", log_addr[1], ab);
                check("R4 B len", 32'(log_len[1]), 32'(lb));
            end
            rd(8'h2C, v); check("R7/R9 slot A status", v, 32'(sa));
            rd(8'h3C, v); check("R7/R8 slot B status", v, 32'(sb));
            rd(8'h04, v); check("R6 ch status", v, ok ? 32'h2 : 32'h4);
            check("R6 seq_done pin", 32'(seq_done), 32'(ok));
            check("R8 seq_err pin", 32'(seq_err), 32'(!ok));
        end

        // R10 / R11 writes while busy
        fail_a = 0; fail_b = 0; lat = 6;
        wr(8'h20, 32'h0040_0000); wr(8'h28, 32'hAAAA_0000);
        wr(8'h30, 32'h0050_0000); wr(8'h38, 32'hBBBB_0000);
        n_iss = 0;
        wr(8'h00, 32'h7);
        wr(8'h28, 32'h5555_5555);
        wr(8'h00, 32'h7);
        wr(8'h30, 32'h0001_0001);
        wait_idle();
        repeat (8) @(negedge clk);
        check("R11 single sequence", 32'(n_iss), 2);
        rd(8'h28, v); check("R10 A addr kept", v, 32'hAAAA_0000);
        rd(8'h30, v); check("R10 B ctrl kept", v, 32'h0050_0000);
        check("R10 B issued addr", log_addr[1], 32'hBBBB_0000);
        rd(8'h04, v); check("R6 ch done after busy writes", v, 32'h2);

        // R12 new start clears previous error status
        wr(8'h20, 32'h0040_0001);
        wr(8'h00, 32'h7); wait_idle();
        rd(8'h04, v); check("R9 rejection error", v, 32'h4);
        wr(8'h20, 32'h0040_0000); lat = 1;
        wr(8'h00, 32'h7);
        rd(8'h3C, v);
        wait_idle(); repeat (3) @(negedge clk);
        rd(8'h2C, v); check("R12 A status renewed", v, 32'h1);
        rd(8'h04, v); check("R12 error cleared", v, 32'h2);

        finish_up();
    end
endmodule